// File: doc/BRIEF.md
# Pipeline Register Bank with Hold and Flush

This block is the register set that separates two pipeline stages. It holds a
configurable list of named fields. Each field has its own width and its own
default constant. The earlier stage drives every field's next value onto a
packed input vector. The later stage reads the registered copy from a packed
output vector. Field 0 sits in the least significant bits and each later field
sits directly above the one before it.

Two controls come from the hazard logic, which is outside this block. The hold
control (`stall`) keeps every field at its present value. The flush control
(`bubble`) replaces every field with its default constant, so a no-op enters
the later stage. With neither control active, the bank captures its inputs on
each rising clock edge. A synchronous reset also loads the defaults.

Each cycle, the control decoder selects one of four named modes:
`BK_RESET`, `BK_BUBBLE`, `BK_HOLD` and `BK_CAPTURE`. The priority order is:
1. reset
2. bubble
3. stall
4. capture

Every field register applies the selected mode at the same edge. No mode
remembers anything about the previous cycle, so any mode can follow any other
mode.

Top module: `pipe_bank`

## Requirements
- R1: With the default parameters there are two fields. Field 0 is 3 bits wide in `q_out[2:0]` with default 2. Field 1 is 5 bits wide in `q_out[7:3]` with default 0. The full default word is therefore 8'h02.
- R2: When `bubble` is high at a rising edge and `rst` is low, every field takes its own default after that edge, whatever `d_in` holds.
- R3: When `stall` is high, `bubble` is low and `rst` is low at a rising edge, `q_out` keeps its value across that edge, whatever `d_in` holds.
- R4: When `rst`, `stall` and `bubble` are all low at a rising edge, `q_out` equals the `d_in` value sampled at that edge.
- R5: When `stall` and `bubble` are both high at an edge, the bubble wins and the defaults are loaded.
- R6: Reset is synchronous. `rst` high at a rising edge loads every default and overrides both controls. Raising `rst` between edges leaves `q_out` unchanged until the next edge.
- R7: All fields change at the same edge. Values in consecutive cycles take effect one cycle apart, with no added latency, and each field takes its own slice independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; loads the defaults |
| stall | input | 1 | Hold control: keeps all fields unchanged |
| bubble | input | 1 | Flush control: loads all field defaults; overrides `stall` |
| d_in | input | TOTAL_W | Packed next values from the earlier stage |
| q_out | output | TOTAL_W | Packed registered fields for the later stage |

## Verification
The hold and flush controls can both be active in the same cycle. The bench sets both before an edge, with `q_out` holding a non-default value and `d_in` carrying a third, distinct pattern. That way each of the three possible outcomes (held value, captured input, defaults) is distinguishable. Only the default word 8'h02 counts as correct. Reset is also raised together with a hold, to confirm that reset overrides it. Separately, reset is raised between edges, to confirm that nothing changes before the next edge.

// File: rtl/pipe_bank_pkg.sv
package pipe_bank_pkg;

    localparam int unsigned MAX_FIELDS = 8;
    localparam int unsigned MAX_BITS   = MAX_FIELDS * 32;

    typedef int unsigned field_list_t [MAX_FIELDS];

    typedef enum logic [1:0] {
        BK_CAPTURE = 2'd0,
        BK_HOLD    = 2'd1,
        BK_BUBBLE  = 2'd2,
        BK_RESET   = 2'd3
    } bank_mode_e;

    function automatic int unsigned total_width(field_list_t w, int unsigned n);
        int unsigned s = 0;
        for (int unsigned i = 0; i < MAX_FIELDS; i++) begin
            if (i < n) s += w[i];
        end
        return s;
    endfunction

    function automatic int unsigned field_offset(field_list_t w, int unsigned k);
        int unsigned s = 0;
        for (int unsigned i = 0; i < MAX_FIELDS; i++) begin
            if (i < k) s += w[i];
        end
        return s;
    endfunction

    function automatic logic [MAX_BITS-1:0] default_vector(field_list_t w,
                                                           field_list_t r,
                                                           int unsigned n);
        logic [MAX_BITS-1:0] v = '0;
        int unsigned off = 0;
        for (int unsigned i = 0; i < MAX_FIELDS; i++) begin
            if (i < n) begin
                for (int unsigned b = 0; b < 32; b++) begin
                    if (b < w[i]) v[off + b] = r[i][b];
                end
                off += w[i];
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/pipe_bank_ctrl.sv
module pipe_bank_ctrl
    import pipe_bank_pkg::*;
(
    input  logic       rst,
    input  logic       stall,
    input  logic       bubble,
    output bank_mode_e mode
);

    // Priority: reset, then flush, then hold, then capture.
    always_comb begin
        if (rst)         mode = BK_RESET;
        else if (bubble) mode = BK_BUBBLE;
        else if (stall)  mode = BK_HOLD;
        else             mode = BK_CAPTURE;
    end

endmodule

// File: rtl/pipe_bank_field.sv
module pipe_bank_field
    import pipe_bank_pkg::*;
#(
    parameter int unsigned W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  bank_mode_e   mode,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        unique case (mode)
            BK_RESET:   q <= RST_VAL;
            BK_BUBBLE:  q <= RST_VAL;
            BK_HOLD:    q <= q;
            BK_CAPTURE: q <= d;
            default:    q <= RST_VAL;
        endcase
    end

endmodule

// File: rtl/pipe_bank.sv
module pipe_bank
    import pipe_bank_pkg::*;
#(
    parameter int unsigned NUM_FIELDS = 2,
    parameter field_list_t FIELD_W    = '{3, 5, 0, 0, 0, 0, 0, 0},
    parameter field_list_t FIELD_RST  = '{2, 0, 0, 0, 0, 0, 0, 0},
    localparam int unsigned TOTAL_W   = total_width(FIELD_W, NUM_FIELDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    input  logic               bubble,
    input  logic [TOTAL_W-1:0] d_in,
    output logic [TOTAL_W-1:0] q_out
);

    localparam logic [MAX_BITS-1:0] DEF_ALL = default_vector(FIELD_W, FIELD_RST, NUM_FIELDS);
    localparam logic [TOTAL_W-1:0]  DEF_VEC = DEF_ALL[TOTAL_W-1:0];

    bank_mode_e mode;

    pipe_bank_ctrl u_ctrl (
        .rst    (rst),
        .stall  (stall),
        .bubble (bubble),
        .mode   (mode)
    );

    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
        localparam int unsigned LO = field_offset(FIELD_W, k);
        localparam int unsigned FW = FIELD_W[k];
        localparam logic [FW-1:0] RV = DEF_VEC[LO +: FW];

        pipe_bank_field #(
            .W       (FW),
            .RST_VAL (RV)
        ) u_field (
            .clk  (clk),
            .mode (mode),
            .d    (d_in[LO +: FW]),
            .q    (q_out[LO +: FW])
        );
    end

endmodule

// File: rtl/pipe_bank_chk.sv
module pipe_bank_chk #(
    parameter int unsigned        TOTAL_W = 8,
    parameter logic [TOTAL_W-1:0] DEF_VEC = '0
) (
    input logic               clk,
    input logic               rst,
    input logic               stall,
    input logic               bubble,
    input logic [TOTAL_W-1:0] d_in,
    input logic [TOTAL_W-1:0] q_out
);

    AST_RESET_DEFAULT: assert property (@(posedge clk) rst |=> q_out == DEF_VEC); // R6

    AST_BUBBLE_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (bubble && !stall) |=> q_out == DEF_VEC); // R2

    AST_BUBBLE_OVER_STALL: assert property (@(posedge clk) disable iff (rst)
        (bubble && stall) |=> q_out == DEF_VEC); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stall && !bubble) |=> $stable(q_out)); // R3

    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!stall && !bubble) |=> q_out == $past(d_in)); // R4

endmodule

bind pipe_bank pipe_bank_chk #(
    .TOTAL_W (TOTAL_W),
    .DEF_VEC (DEF_VEC)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .stall  (stall),
    .bubble (bubble),
    .d_in   (d_in),
    .q_out  (q_out)
);

// File: tb/sim_pipe_bank.sv
module sim_pipe_bank;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] DEF = 8'h02;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stall = 1'b0;
    logic       bubble = 1'b0;
    logic [7:0] d_in = 8'h00;
    logic [7:0] q_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    pipe_bank u0 (
        .clk    (clk),
        .rst    (rst),
        .stall  (stall),
        .bubble (bubble),
        .d_in   (d_in),
        .q_out  (q_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive between edges, then sample shortly after the next rising edge.
    task automatic step(input logic r, input logic s, input logic b, input logic [7:0] d);
        @(negedge clk);
        rst = r; stall = s; bubble = b; d_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        step(1'b1, 1'b0, 1'b0, 8'hFF);
        check("R6 reset loads defaults", q_out, DEF);
        check("R1 field0 default 2", {5'd0, q_out[2:0]}, 8'd2);
        check("R1 field1 default 0", {3'd0, q_out[7:3]}, 8'd0);
    endtask

    task automatic t_capture();
        step(1'b0, 1'b0, 1'b0, {5'd22, 3'd5});
        check("R4 capture", q_out, {5'd22, 3'd5});
        check("R1 field0 slice", {5'd0, q_out[2:0]}, 8'd5);
        check("R1 field1 slice", {3'd0, q_out[7:3]}, 8'd22);
    endtask

    task automatic t_stall();
        step(1'b0, 1'b0, 1'b0, 8'hA7);
        step(1'b0, 1'b1, 1'b0, 8'h3C);
        check("R3 stall holds", q_out, 8'hA7);
        step(1'b0, 1'b1, 1'b0, 8'h51);
        check("R3 stall holds second cycle", q_out, 8'hA7);
        step(1'b0, 1'b0, 1'b0, 8'h51);
        check("R4 capture after stall", q_out, 8'h51);
    endtask

    task automatic t_bubble();
        step(1'b0, 1'b0, 1'b0, 8'hF8);
        step(1'b0, 1'b0, 1'b1, 8'hFF);
        check("R2 bubble loads defaults", q_out, DEF);
        step(1'b0, 1'b0, 1'b0, 8'h9D);
        check("R4 capture after bubble", q_out, 8'h9D);
    endtask

    task automatic t_both();
        step(1'b0, 1'b0, 1'b0, 8'hE9);
        step(1'b0, 1'b1, 1'b1, 8'h74);
        check("R5 bubble over stall", q_out, DEF);
        step(1'b0, 1'b0, 1'b0, 8'hC3);
        step(1'b1, 1'b1, 1'b0, 8'h66);
        check("R6 reset over stall", q_out, DEF);
    endtask

    task automatic t_sync_reset();
        step(1'b0, 1'b0, 1'b0, 8'hB5);
        @(negedge clk);
        rst = 1'b1; d_in = 8'h00;
        #1;
        check("R6 reset waits for edge", q_out, 8'hB5);
        @(posedge clk);
        #1;
        check("R6 reset applied at edge", q_out, DEF);
    endtask

    task automatic t_sequence();
        step(1'b0, 1'b0, 1'b0, {5'd1, 3'd7});
        check("R7 seq cycle 1", q_out, {5'd1, 3'd7});
        step(1'b0, 1'b0, 1'b0, {5'd31, 3'd0});
        check("R7 seq cycle 2", q_out, {5'd31, 3'd0});
        step(1'b0, 1'b0, 1'b0, {5'd10, 3'd3});
        check("R7 seq cycle 3", q_out, {5'd10, 3'd3});
    endtask

    initial begin
        step(1'b1, 1'b0, 1'b0, 8'h00);
        t_reset();
        t_capture();
        t_stall();
        t_bubble();
        t_both();
        t_sync_reset();
        t_sequence();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule